// File: doc/BRIEF.md
# Virtual Output Queue Deep-Buffer Eviction Controller

This controller watches a group of virtual output queues, one buffer unit per enqueue or dequeue event. It decides when a queue has become congested and must move from the shallow on-chip buffer into the deep external buffer. It also decides when the queue may come back. A queue counts as congested if its head packet has waited too long or if it holds too many buffers. A congested queue stays in the deep buffer until it has drained completely.

Each evicted queue gets a depth limit. The base value is the limit configured for that queue. If no limit is configured, the base is a default equal to six milliseconds of buffering at the port rate. The controller keeps a running total of the buffers that all evicted queues hold in the deep buffer. It sorts that total into one of four brackets, and each bracket has its own cap. As the total rises, the cap falls, and the lower cap applies at once to every evicted queue, including queues that were evicted earlier. Arrivals to an evicted queue that is at or above its effective limit are tail dropped. The memories and the data movement are outside this block; it only produces the decisions.

Top module: `vq_evict_ctrl`

## Requirements
- R1: Each queue has a head age counter. The counter goes to 0 in any cycle where the queue is empty or a dequeue is applied to it. Otherwise it increases by one per cycle, saturating at its maximum. A queue whose age is strictly greater than `age_thr` is congested.
- R2: A queue whose occupancy is strictly greater than `occ_thr` is congested.
- R3: A queue that is congested and not yet evicted shows its bit set in `evicted_o` from the next clock edge. The bit stays set while the queue holds any buffers.
- R4: An evicted queue returns to the shallow buffer (its bit clears at the next edge) only in a cycle where its occupancy is zero and no enqueue is accepted for it.
- R5: The base limit of queue q is field q of `cfg_lim` (bits q*OW upward) when `cfg_lim_set[q]` is 1. Otherwise it is 6 × `PORT_UNITS_PER_MS`.
- R6: `bracket_o` is the number of the three thresholds in `bkt_thr` (field k at bits k*UW, ascending) that `usage_o` is greater than or equal to. Field q of `qlim_o` is the minimum of the queue's base limit and field `bracket_o` of `bkt_cap`. The limit is recomputed every cycle for all queues.
- R7: An enqueue is dropped if its queue is evicted and its occupancy is greater than or equal to its `qlim_o` field. It is also dropped if the occupancy is at its maximum value. A dropped enqueue does not change occupancy, and `drop_o` is 1 for exactly the cycle after it.
- R8: `usage_o` is the sum of the occupancies of all evicted queues. It is kept as a running counter: on eviction it takes in the queue's occupancy after that cycle's events, and after that it follows every accepted enqueue and applied dequeue of the evicted queues.
- R9: A dequeue to an empty queue has no effect. An enqueue and a dequeue to the same queue in one cycle leave its occupancy unchanged.
- R10: While `rst` is high, all queues are empty and not evicted, `usage_o` and `bracket_o` are 0, and `drop_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_vld | input | 1 | One buffer arrives this cycle |
| enq_qid | input | QW | Queue of the arrival |
| deq_vld | input | 1 | One buffer leaves this cycle |
| deq_qid | input | QW | Queue of the departure |
| age_thr | input | AW | Head age threshold for congestion |
| occ_thr | input | OW | Occupancy threshold for congestion |
| cfg_lim | input | NQ*OW | Configured limit per queue |
| cfg_lim_set | input | NQ | Per queue: configured limit is present |
| bkt_thr | input | 3*UW | Ascending deep-buffer usage thresholds |
| bkt_cap | input | 4*OW | Per-queue cap of each bracket |
| evicted_o | output | NQ | Per queue: held in the deep buffer |
| usage_o | output | UW | Total deep-buffer occupancy |
| bracket_o | output | 2 | Current usage bracket |
| qlim_o | output | NQ*OW | Effective limit per queue |
| drop_o | output | 1 | Previous cycle's arrival was tail dropped |

## Verification
The stimulus drives several patterns. A burst into one queue evicts it through occupancy alone. A single parked packet evicts its queue through age alone, which separates the two congestion causes. Heavy filling of two queues with different base limits pushes the usage through brackets, so the bench can tell a configured limit from the default and a base limit from a bracket cap, including on a queue that was evicted earlier. Draining past empty, dequeues to empty queues, and paired enqueue/dequeue cycles separate a correct return and a correct usage count from off-by-one and premature-return faults.

// File: rtl/vqe_pkg.sv
package vqe_pkg;

    localparam int NUM_BKT = 4;
    localparam int NUM_THR = NUM_BKT - 1;

    typedef enum logic [1:0] {
        BKT_LOW  = 2'd0,
        BKT_MID  = 2'd1,
        BKT_HIGH = 2'd2,
        BKT_FULL = 2'd3
    } bkt_e;

    typedef struct packed {
        logic drop;
        logic accept;
    } admit_t;

    function automatic logic [31:0] umin32(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/vqe_queue_slot.sv
module vqe_queue_slot #(
    parameter int OW = 12,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec_req,
    input  logic [AW-1:0] age_thr,
    input  logic [OW-1:0] occ_thr,
    output logic [OW-1:0] occ,
    output logic [AW-1:0] age,
    output logic          evicted,
    output logic [OW-1:0] add_amt,
    output logic          sub
);
    localparam logic [AW-1:0] AGE_MAX = '1;

    logic [OW-1:0] occ_q, occ_n;
    logic [AW-1:0] age_q, age_n;
    logic          ev_q, ev_n;
    logic          dec, cong;

    always_comb begin
        dec   = dec_req && (occ_q != '0);
        occ_n = occ_q + OW'(inc) - OW'(dec);
        cong  = (age_q > age_thr) || (occ_q > occ_thr);
        if (ev_q)
            ev_n = !((occ_q == '0) && !inc);
        else
            ev_n = cong;
        if (dec || (occ_q == '0))
            age_n = '0;
        else if (age_q == AGE_MAX)
            age_n = age_q;
        else
            age_n = age_q + AW'(1);
        add_amt = '0;
        sub     = 1'b0;
        if (!ev_q && ev_n) begin
            add_amt = occ_n;
        end else if (ev_q && ev_n) begin
            add_amt = OW'(inc);
            sub     = dec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
            age_q <= '0;
            ev_q  <= 1'b0;
        end else begin
            occ_q <= occ_n;
            age_q <= age_n;
            ev_q  <= ev_n;
        end
    end

    assign occ     = occ_q;
    assign age     = age_q;
    assign evicted = ev_q;
endmodule

// File: rtl/vqe_usage.sv
module vqe_usage #(
    parameter int NQ = 8,
    parameter int OW = 12,
    parameter int UW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NQ*OW-1:0] add_flat,
    input  logic [NQ-1:0]    sub,
    output logic [UW-1:0]    usage
);
    logic [UW-1:0] use_q, use_n;

    always_comb begin
        use_n = use_q;
        for (int i = 0; i < NQ; i++) begin
            use_n = use_n + UW'(add_flat[i*OW +: OW]) - UW'(sub[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) use_q <= '0;
        else     use_q <= use_n;
    end

    assign usage = use_q;
endmodule

// File: rtl/vqe_bracket.sv
module vqe_bracket
    import vqe_pkg::*;
#(
    parameter int OW = 12,
    parameter int UW = 16
) (
    input  logic [UW-1:0]         usage,
    input  logic [NUM_THR*UW-1:0] thr_flat,
    input  logic [NUM_BKT*OW-1:0] cap_flat,
    output bkt_e                  bkt,
    output logic [OW-1:0]         cap
);
    logic [1:0] cnt;

    always_comb begin
        cnt = 2'd0;
        for (int k = 0; k < NUM_THR; k++) begin
            if (usage >= thr_flat[k*UW +: UW]) cnt = cnt + 2'd1;
        end
        bkt = bkt_e'(cnt);
        cap = cap_flat[int'(cnt)*OW +: OW];
    end
endmodule

// File: rtl/vq_evict_ctrl.sv
module vq_evict_ctrl
    import vqe_pkg::*;
#(
    parameter int NQ = 8,
    parameter int OW = 12,
    parameter int AW = 10,
    parameter int PORT_UNITS_PER_MS = 100,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int UW = OW + QW + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enq_vld,
    input  logic [QW-1:0]         enq_qid,
    input  logic                  deq_vld,
    input  logic [QW-1:0]         deq_qid,
    input  logic [AW-1:0]         age_thr,
    input  logic [OW-1:0]         occ_thr,
    input  logic [NQ*OW-1:0]      cfg_lim,
    input  logic [NQ-1:0]         cfg_lim_set,
    input  logic [NUM_THR*UW-1:0] bkt_thr,
    input  logic [NUM_BKT*OW-1:0] bkt_cap,
    output logic [NQ-1:0]         evicted_o,
    output logic [UW-1:0]         usage_o,
    output logic [1:0]            bracket_o,
    output logic [NQ*OW-1:0]      qlim_o,
    output logic                  drop_o
);
    localparam int            DEF_LIMIT = 6 * PORT_UNITS_PER_MS;
    localparam logic [OW-1:0] DEF_LIM_V = OW'(DEF_LIMIT);
    localparam logic [OW-1:0] OCC_MAX   = '1;

    logic [NQ*OW-1:0] occ_flat;
    logic [NQ*AW-1:0] age_flat;
    logic [NQ*OW-1:0] add_flat;
    logic [NQ-1:0]    sub_v;
    logic [NQ-1:0]    ev_v;
    logic [NQ-1:0]    inc_v;
    logic [NQ-1:0]    dreq_v;
    logic [NQ*OW-1:0] lim_flat;
    logic [OW-1:0]    cur_cap;
    bkt_e             cur_bkt;
    logic [UW-1:0]    usage;
    admit_t           adm;
    logic             drop_q;

    vqe_bracket #(.OW(OW), .UW(UW)) u_bkt (
        .usage    (usage),
        .thr_flat (bkt_thr),
        .cap_flat (bkt_cap),
        .bkt      (cur_bkt),
        .cap      (cur_cap)
    );

    genvar g;
    generate
        for (g = 0; g < NQ; g++) begin : g_q
            logic [OW-1:0] base;
            assign base = cfg_lim_set[g] ? cfg_lim[g*OW +: OW] : DEF_LIM_V;
            assign lim_flat[g*OW +: OW] = OW'(umin32(32'(base), 32'(cur_cap)));
            assign inc_v[g]  = adm.accept && (enq_qid == QW'(g));
            assign dreq_v[g] = deq_vld && (deq_qid == QW'(g));

            vqe_queue_slot #(.OW(OW), .AW(AW)) u_slot (
                .clk     (clk),
                .rst     (rst),
                .inc     (inc_v[g]),
                .dec_req (dreq_v[g]),
                .age_thr (age_thr),
                .occ_thr (occ_thr),
                .occ     (occ_flat[g*OW +: OW]),
                .age     (age_flat[g*AW +: AW]),
                .evicted (ev_v[g]),
                .add_amt (add_flat[g*OW +: OW]),
                .sub     (sub_v[g])
            );
        end
    endgenerate

    vqe_usage #(.NQ(NQ), .OW(OW), .UW(UW)) u_use (
        .clk      (clk),
        .rst      (rst),
        .add_flat (add_flat),
        .sub      (sub_v),
        .usage    (usage)
    );

    always_comb begin
        logic [OW-1:0] o;
        logic [OW-1:0] l;
        logic          e;
        adm = '0;
        o = '0;
        l = '0;
        e = 1'b0;
        if (enq_vld && (int'(enq_qid) < NQ)) begin
            o = occ_flat[int'(enq_qid)*OW +: OW];
            l = lim_flat[int'(enq_qid)*OW +: OW];
            e = ev_v[int'(enq_qid)];
            adm.drop   = (e && (o >= l)) || (o == OCC_MAX);
            adm.accept = !adm.drop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) drop_q <= 1'b0;
        else     drop_q <= adm.drop;
    end

    assign evicted_o = ev_v;
    assign usage_o   = usage;
    assign bracket_o = 2'(cur_bkt);
    assign qlim_o    = lim_flat;
    assign drop_o    = drop_q;
endmodule

// File: rtl/vq_evict_ctrl_chk.sv
module vq_evict_ctrl_chk #(
    parameter int NQ = 8,
    parameter int OW = 12,
    parameter int AW = 10,
    parameter int QW = 3,
    parameter int UW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             enq_vld,
    input logic [QW-1:0]    enq_qid,
    input logic [AW-1:0]    age_thr,
    input logic [OW-1:0]    occ_thr,
    input logic [NQ-1:0]    evicted_o,
    input logic [UW-1:0]    usage_o,
    input logic [NQ*OW-1:0] qlim_o,
    input logic [NQ*OW-1:0] occ_flat,
    input logic [NQ*AW-1:0] age_flat,
    input logic             drop_o
);
    a_r8_no_evicted_no_usage: assert property (@(posedge clk) disable iff (rst)
        (evicted_o == '0) |-> (usage_o == '0));

    a_r7_drop_needs_arrival: assert property (@(posedge clk) disable iff (rst)
        drop_o |-> $past(enq_vld));

    genvar g;
    generate
        for (g = 0; g < NQ; g++) begin : g_chk
            a_r4_return_only_empty: assert property (@(posedge clk) disable iff (rst)
                $fell(evicted_o[g]) |-> ($past(occ_flat[g*OW +: OW]) == '0));

            a_r3_evict_needs_congestion: assert property (@(posedge clk) disable iff (rst)
                $rose(evicted_o[g]) |->
                    ($past(age_flat[g*AW +: AW] > age_thr) || $past(occ_flat[g*OW +: OW] > occ_thr)));

            a_r7_full_queue_drops: assert property (@(posedge clk) disable iff (rst)
                (enq_vld && (enq_qid == QW'(g)) && evicted_o[g] &&
                 (occ_flat[g*OW +: OW] >= qlim_o[g*OW +: OW])) |=> drop_o);
        end
    endgenerate
endmodule

bind vq_evict_ctrl vq_evict_ctrl_chk #(
    .NQ(NQ), .OW(OW), .AW(AW), .QW(QW), .UW(UW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enq_vld   (enq_vld),
    .enq_qid   (enq_qid),
    .age_thr   (age_thr),
    .occ_thr   (occ_thr),
    .evicted_o (evicted_o),
    .usage_o   (usage_o),
    .qlim_o    (qlim_o),
    .occ_flat  (occ_flat),
    .age_flat  (age_flat),
    .drop_o    (drop_o)
);

// File: tb/vq_evict_ctrl_tb_top.sv
module vq_evict_ctrl_tb_top;
    localparam int NQ = 8;
    localparam int OW = 12;
    localparam int AW = 10;
    localparam int PU = 2;
    localparam int QW = 3;
    localparam int UW = OW + QW + 1;
    localparam int DEF_L = 6 * PU;
    localparam int OCC_T = 4;
    localparam int AGE_T = 30;
    localparam int OCC_SAT = (1 << OW) - 1;
    localparam int AGE_SAT = (1 << AW) - 1;
    localparam int THR [3] = '{8, 16, 24};
    localparam int CAP [4] = '{20, 10, 6, 3};

    // {enq_v, enq_q[2:0], deq_v, deq_q[2:0], repeat[7:0]}
    localparam int NV = 14;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 3'd0, 1'b0, 3'd0, 8'd7},
        {1'b1, 3'd1, 1'b0, 3'd0, 8'd10},
        {1'b1, 3'd0, 1'b0, 3'd0, 8'd4},
        {1'b1, 3'd2, 1'b0, 3'd0, 8'd1},
        {1'b0, 3'd0, 1'b0, 3'd0, 8'd35},
        {1'b1, 3'd3, 1'b0, 3'd0, 8'd3},
        {1'b0, 3'd0, 1'b1, 3'd0, 8'd12},
        {1'b1, 3'd0, 1'b1, 3'd1, 8'd3},
        {1'b0, 3'd0, 1'b1, 3'd1, 8'd14},
        {1'b1, 3'd4, 1'b1, 3'd4, 8'd5},
        {1'b0, 3'd0, 1'b1, 3'd2, 8'd2},
        {1'b0, 3'd0, 1'b1, 3'd3, 8'd4},
        {1'b0, 3'd0, 1'b1, 3'd4, 8'd2},
        {1'b0, 3'd0, 1'b1, 3'd0, 8'd4}
    };

    logic clk = 1'b0;
    logic rst;
    logic enq_vld, deq_vld;
    logic [QW-1:0] enq_qid, deq_qid;
    logic [AW-1:0] age_thr;
    logic [OW-1:0] occ_thr;
    logic [NQ*OW-1:0] cfg_lim;
    logic [NQ-1:0] cfg_lim_set;
    logic [3*UW-1:0] bkt_thr;
    logic [4*OW-1:0] bkt_cap;
    logic [NQ-1:0] evicted_o;
    logic [UW-1:0] usage_o;
    logic [1:0] bracket_o;
    logic [NQ*OW-1:0] qlim_o;
    logic drop_o;

    always #4 clk = ~clk;

    vq_evict_ctrl #(.NQ(NQ), .OW(OW), .AW(AW), .PORT_UNITS_PER_MS(PU)) dut_i (
        .clk(clk), .rst(rst),
        .enq_vld(enq_vld), .enq_qid(enq_qid),
        .deq_vld(deq_vld), .deq_qid(deq_qid),
        .age_thr(age_thr), .occ_thr(occ_thr),
        .cfg_lim(cfg_lim), .cfg_lim_set(cfg_lim_set),
        .bkt_thr(bkt_thr), .bkt_cap(bkt_cap),
        .evicted_o(evicted_o), .usage_o(usage_o), .bracket_o(bracket_o),
        .qlim_o(qlim_o), .drop_o(drop_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_occ [NQ];
    int m_age [NQ];
    bit m_ev [NQ];
    int m_use;
    bit m_drop;

    function automatic int m_base(int q);
        return (q == 0) ? 9 : DEF_L;
    endfunction

    function automatic int m_bkt(int u);
        int b = 0;
        for (int k = 0; k < 3; k++) if (u >= THR[k]) b++;
        return b;
    endfunction

    function automatic int m_lim(int q, int u);
        int c = CAP[m_bkt(u)];
        return (m_base(q) < c) ? m_base(q) : c;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        for (int q = 0; q < NQ; q++) begin
            chk("R3/R4 evicted bit", int'(evicted_o[q]), int'(m_ev[q]));
            chk("R5/R6 queue limit", int'(qlim_o[q*OW +: OW]), m_lim(q, m_use));
        end
        chk("R8 usage", int'(usage_o), m_use);
        chk("R6 bracket", int'(bracket_o), m_bkt(m_use));
        chk("R7 drop", int'(drop_o), int'(m_drop));
    endtask

    task automatic step(bit e, int eq, bit d, int dq);
        int lim, nu;
        bit acc;
        enq_vld = e; enq_qid = QW'(eq);
        deq_vld = d; deq_qid = QW'(dq);
        lim = m_lim(eq, m_use);
        m_drop = e && ((m_ev[eq] && m_occ[eq] >= lim) || m_occ[eq] == OCC_SAT);
        acc = e && !m_drop;
        nu = m_use;
        for (int q = 0; q < NQ; q++) begin
            int inc, dec, on;
            bit cong, evn;
            inc = (acc && eq == q) ? 1 : 0;
            dec = (d && dq == q && m_occ[q] > 0) ? 1 : 0;
            on = m_occ[q] + inc - dec;
            cong = (m_age[q] > AGE_T) || (m_occ[q] > OCC_T);
            evn = m_ev[q] ? !(m_occ[q] == 0 && inc == 0) : cong;
            if (m_ev[q] && evn) nu = nu + inc - dec;
            else if (!m_ev[q] && evn) nu = nu + on;
            if (dec != 0 || m_occ[q] == 0) m_age[q] = 0;
            else if (m_age[q] < AGE_SAT) m_age[q]++;
            m_occ[q] = on;
            m_ev[q] = evn;
        end
        m_use = nu;
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        rst = 1'b1;
        enq_vld = 0; deq_vld = 0; enq_qid = '0; deq_qid = '0;
        age_thr = AW'(AGE_T);
        occ_thr = OW'(OCC_T);
        cfg_lim = '0;
        cfg_lim[0 +: OW] = OW'(9);
        cfg_lim[2*OW +: OW] = OW'(1);
        cfg_lim_set = 8'b0000_0001;
        for (int k = 0; k < 3; k++) bkt_thr[k*UW +: UW] = UW'(THR[k]);
        for (int k = 0; k < 4; k++) bkt_cap[k*OW +: OW] = OW'(CAP[k]);
        for (int q = 0; q < NQ; q++) begin
            m_occ[q] = 0; m_age[q] = 0; m_ev[q] = 0;
        end
        m_use = 0; m_drop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state; R5: configured limit on q0, default on others (field 2 value ignored)
        chk("R10 evicted after reset", int'(evicted_o), 0);
        chk("R10 usage after reset", int'(usage_o), 0);
        chk("R10 bracket after reset", int'(bracket_o), 0);
        chk("R10 drop after reset", int'(drop_o), 0);
        chk("R5 configured limit q0", int'(qlim_o[0 +: OW]), 9);
        chk("R5 default limit q2", int'(qlim_o[2*OW +: OW]), DEF_L);
        rst = 1'b0;
        @(negedge clk);
        check_all();

        // table walk: R1 age eviction, R2 occupancy eviction, R7 tail drop, R9 paired/empty dequeues
        for (int v = 0; v < NV; v++) begin
            for (int r = 0; r < int'(VEC[v][7:0]); r++)
                step(VEC[v][15], int'(VEC[v][14:12]), VEC[v][11], int'(VEC[v][10:8]));
        end

        // directed R2: exactly OCC_T buffers stay shallow, one more evicts on the following edge
        for (int i = 0; i < OCC_T; i++) step(1, 5, 0, 0);
        step(0, 0, 0, 0);
        chk("R2 at threshold not evicted", int'(evicted_o[5]), 0);
        step(1, 5, 0, 0);
        step(0, 0, 0, 0);
        chk("R2 above threshold evicted", int'(evicted_o[5]), 1);
        chk("R8 usage takes queue occupancy", int'(usage_o), OCC_T + 1);

        // directed R6: pushing usage up lowers the cap of the already evicted q5
        for (int i = 0; i < 12; i++) step(1, 6, 0, 0);
        chk("R6 evicted queue limit shrinks", int'(qlim_o[5*OW +: OW]), m_lim(5, m_use));
        chk("R6 bracket raised", int'(bracket_o) > 0 ? 1 : 0, 1);

        // directed R4: drain q5 and q6 to empty, both return
        for (int i = 0; i < OCC_T + 2; i++) step(0, 0, 1, 5);
        for (int i = 0; i < 14; i++) step(0, 0, 1, 6);
        step(0, 0, 0, 0);
        chk("R4 returned after drain", int'(evicted_o), 0);
        chk("R8 usage zero after drain", int'(usage_o), 0);

        // directed R9: dequeue of empty queue leaves it ready to take a fresh buffer
        step(0, 0, 1, 7);
        chk("R9 empty dequeue no eviction", int'(evicted_o[7]), 0);

        // directed R10: reset mid-run clears state
        for (int i = 0; i < 6; i++) step(1, 7, 0, 0);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R10 reset clears evicted", int'(evicted_o), 0);
        chk("R10 reset clears usage", int'(usage_o), 0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule